// File: doc/BRIEF.md
# Fast System-Call Transfer Unit

This block works out the control state that a processor core loads when it takes a fast jump into privileged code or a fast return to user code. Software first loads three configuration registers through a small write port: a base code selector, an entry instruction pointer and an entry stack pointer. A request for entry or exit then yields a complete set of new values one clock later. The set covers the code and stack selectors, the flat segment attributes, the long-mode flag, the new instruction and stack pointers, and a fault flag.

Both segment selectors come from the one configured selector plus fixed offsets. The privilege field of each selector is forced to kernel level on entry and to user level on exit. Address width handling and the canonical-address and NULL-selector checks depend on two mode inputs: `long_en`, which says the extended 64-bit architecture is enabled, and `wide_mode`, which says 64-bit mode is the current mode.

Top module: `fastcall_xfer`

## Requirements
- R1: A synchronous active-high reset clears all three configuration registers and the response outputs to zero.
- R2: A write with `cfg_we` high stores the write data into the register chosen by `cfg_idx`. Index 0 selects the code selector (low 16 bits are kept), index 1 the entry instruction pointer and index 2 the entry stack pointer. Index 3 changes nothing. A request in the same cycle as a write sees the old value.
- R3: Each cycle with a request is followed, one clock later, by a single-cycle `rsp_valid` pulse. After a cycle with no request, `rsp_valid` and all response fields are zero.
- R4: A valid entry gives code selector = configured & 0xFFFC and stack selector = (configured + 8) & 0xFFFC. Both segments get base 0 and limit 0xFFFFFFFF, and `rsp_cs_long` equals `long_en`.
- R5: On entry with `long_en` high the pointers are the full 64-bit register values. With `long_en` low only the lower 32 bits are used and bits 63:32 of the outputs are zero.
- R6: When `wide_mode` and `long_en` are both high, an entry faults if bits 15:2 of the configured selector are all zero, or if either entry pointer is not canonical. An address is canonical when bits 63:47 are all equal. Outside 64-bit mode, neither check applies.
- R7: A valid exit gives code selector = (configured + 32) | 3 and stack selector = (configured + 40) | 3. `rsp_cs_long` is 1, the flat base and limit are as on entry, and the pointers are `ret_ip` and `ret_sp`.
- R8: An exit faults if `ret_ip` or `ret_sp` is not canonical.
- R9: A faulting response has `rsp_valid` and `rsp_fault` high and all selector, attribute and pointer outputs zero.
- R10: Entry and exit requested in the same cycle produce a faulting response.
- R11: Selector offsets are added modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | 2 | Configuration register index |
| cfg_wdata | input | 64 | Configuration write data |
| long_en | input | 1 | Extended 64-bit architecture enabled |
| wide_mode | input | 1 | 64-bit mode currently active |
| enter_req | input | 1 | Fast privileged entry request |
| exit_req | input | 1 | Fast 64-bit user return request |
| ret_ip | input | 64 | Return instruction pointer for exit |
| ret_sp | input | 64 | Return stack pointer for exit |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_fault | output | 1 | Response is a fault |
| rsp_cs | output | 16 | New code selector |
| rsp_ss | output | 16 | New stack selector |
| rsp_cs_base | output | 32 | New code segment base |
| rsp_cs_limit | output | 32 | New code segment limit |
| rsp_cs_long | output | 1 | New code segment long-mode bit |
| rsp_ss_base | output | 32 | New stack segment base |
| rsp_ss_limit | output | 32 | New stack segment limit |
| rsp_ip | output | 64 | New instruction pointer |
| rsp_sp | output | 64 | New stack pointer |

## Verification
The assertions assume that reset is held for at least one clock before any request. Apart from the R10 case, they also assume that entry and exit are not raised together, and that `wide_mode` is only high when `long_en` is high. The random stimulus draws the mode pair only from the three legal combinations. It raises both requests together only in one directed R10 case. Pointers are drawn around the 47-bit sign boundary so that canonical and non-canonical values both show up often.

// File: rtl/fastcall_pkg.sv
package fastcall_pkg;

  typedef enum logic [1:0] {
    CFG_CSEL = 2'd0,
    CFG_EIP  = 2'd1,
    CFG_ESP  = 2'd2,
    CFG_NONE = 2'd3
  } cfg_idx_e;

  localparam int unsigned ENTRY_SS_OFS = 8;
  localparam int unsigned EXIT_CS_OFS  = 32;
  localparam int unsigned EXIT_SS_OFS  = 40;
  localparam logic [1:0]  RPL_KERNEL   = 2'b00;
  localparam logic [1:0]  RPL_USER     = 2'b11;

endpackage

// File: rtl/fastcall_canon.sv
module fastcall_canon #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned VA_W   = 48
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ok
);
  generate
    if (VA_W >= ADDR_W) begin : g_all_ok
      assign ok = 1'b1;
    end else begin : g_check
      localparam int unsigned TOP_W = ADDR_W - VA_W + 1;
      logic [TOP_W-1:0] top_bits;
      assign top_bits = addr[ADDR_W-1:VA_W-1];
      assign ok = (top_bits == '0) || (top_bits == '1);
    end
  endgenerate
endmodule

// File: rtl/fastcall_cfg.sv
module fastcall_cfg
  import fastcall_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SEL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        idx,
  input  logic [ADDR_W-1:0] wdata,
  output logic [SEL_W-1:0]  code_sel,
  output logic [ADDR_W-1:0] entry_ip,
  output logic [ADDR_W-1:0] entry_sp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_sel <= '0;
      entry_ip <= '0;
      entry_sp <= '0;
    end else if (we) begin
      case (cfg_idx_e'(idx))
        CFG_CSEL: code_sel <= wdata[SEL_W-1:0];
        CFG_EIP:  entry_ip <= wdata;
        CFG_ESP:  entry_sp <= wdata;
        default:  ;
      endcase
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (code_sel == '0 && entry_ip == '0 && entry_sp == '0));

  a_r2_spare_index_inert: assert property (@(posedge clk) disable iff (rst)
    (we && idx == 2'd3) |=> ($stable(code_sel) && $stable(entry_ip) && $stable(entry_sp)));
endmodule

// File: rtl/fastcall_calc.sv
module fastcall_calc
  import fastcall_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SEL_W  = 16,
  parameter int unsigned VA_W   = 48,
  parameter int unsigned LIM_W  = 32
) (
  input  logic              enter,
  input  logic              leave,
  input  logic              long_en,
  input  logic              wide_mode,
  input  logic [SEL_W-1:0]  code_sel,
  input  logic [ADDR_W-1:0] entry_ip,
  input  logic [ADDR_W-1:0] entry_sp,
  input  logic [ADDR_W-1:0] ret_ip,
  input  logic [ADDR_W-1:0] ret_sp,
  output logic              fault,
  output logic [SEL_W-1:0]  cs,
  output logic [SEL_W-1:0]  ss,
  output logic [LIM_W-1:0]  base,
  output logic [LIM_W-1:0]  limit,
  output logic              cs_long,
  output logic [ADDR_W-1:0] ip,
  output logic [ADDR_W-1:0] sp
);
  localparam int unsigned NCHK  = 4;
  localparam int unsigned LOW_W = 32;

  logic [NCHK-1:0][ADDR_W-1:0] chk_addr;
  logic [NCHK-1:0]             chk_ok;

  assign chk_addr[0] = entry_ip;
  assign chk_addr[1] = entry_sp;
  assign chk_addr[2] = ret_ip;
  assign chk_addr[3] = ret_sp;

  generate
    for (genvar gi = 0; gi < NCHK; gi++) begin : g_canon
      fastcall_canon #(.ADDR_W(ADDR_W), .VA_W(VA_W)) u_canon (
        .addr (chk_addr[gi]),
        .ok   (chk_ok[gi])
      );
    end
  endgenerate

  logic             m64;
  logic             sel_null;
  logic [SEL_W-1:0] sel_p8, sel_p32, sel_p40;
  logic             entry_bad, exit_bad;

  assign m64       = wide_mode & long_en;
  assign sel_null  = (code_sel[SEL_W-1:2] == '0);
  assign sel_p8    = code_sel + SEL_W'(ENTRY_SS_OFS);
  assign sel_p32   = code_sel + SEL_W'(EXIT_CS_OFS);
  assign sel_p40   = code_sel + SEL_W'(EXIT_SS_OFS);
  assign entry_bad = m64 && (sel_null || !chk_ok[0] || !chk_ok[1]);
  assign exit_bad  = !chk_ok[2] || !chk_ok[3];

  function automatic logic [ADDR_W-1:0] narrow(input logic [ADDR_W-1:0] a, input logic wide);
    return wide ? a : {{(ADDR_W-LOW_W){1'b0}}, a[LOW_W-1:0]};
  endfunction

  always_comb begin
    fault   = 1'b0;
    cs      = '0;
    ss      = '0;
    base    = '0;
    limit   = '0;
    cs_long = 1'b0;
    ip      = '0;
    sp      = '0;
    if (enter && leave) begin
      fault = 1'b1;
    end else if (enter) begin
      if (entry_bad) begin
        fault = 1'b1;
      end else begin
        cs      = {code_sel[SEL_W-1:2], RPL_KERNEL};
        ss      = {sel_p8[SEL_W-1:2], RPL_KERNEL};
        limit   = '1;
        cs_long = long_en;
        ip      = narrow(entry_ip, long_en);
        sp      = narrow(entry_sp, long_en);
      end
    end else if (leave) begin
      if (exit_bad) begin
        fault = 1'b1;
      end else begin
        cs      = {sel_p32[SEL_W-1:2], RPL_USER};
        ss      = {sel_p40[SEL_W-1:2], RPL_USER};
        limit   = '1;
        cs_long = 1'b1;
        ip      = ret_ip;
        sp      = ret_sp;
      end
    end
  end
endmodule

// File: rtl/fastcall_xfer.sv
module fastcall_xfer #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SEL_W  = 16,
  parameter int unsigned VA_W   = 48,
  parameter int unsigned LIM_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_idx,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              long_en,
  input  logic              wide_mode,
  input  logic              enter_req,
  input  logic              exit_req,
  input  logic [ADDR_W-1:0] ret_ip,
  input  logic [ADDR_W-1:0] ret_sp,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [SEL_W-1:0]  rsp_cs,
  output logic [SEL_W-1:0]  rsp_ss,
  output logic [LIM_W-1:0]  rsp_cs_base,
  output logic [LIM_W-1:0]  rsp_cs_limit,
  output logic              rsp_cs_long,
  output logic [LIM_W-1:0]  rsp_ss_base,
  output logic [LIM_W-1:0]  rsp_ss_limit,
  output logic [ADDR_W-1:0] rsp_ip,
  output logic [ADDR_W-1:0] rsp_sp
);
  logic [SEL_W-1:0]  code_sel;
  logic [ADDR_W-1:0] entry_ip, entry_sp;

  fastcall_cfg #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .idx      (cfg_idx),
    .wdata    (cfg_wdata),
    .code_sel (code_sel),
    .entry_ip (entry_ip),
    .entry_sp (entry_sp)
  );

  logic              n_fault, n_long;
  logic [SEL_W-1:0]  n_cs, n_ss;
  logic [LIM_W-1:0]  n_base, n_limit;
  logic [ADDR_W-1:0] n_ip, n_sp;

  fastcall_calc #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .VA_W(VA_W), .LIM_W(LIM_W)) u_calc (
    .enter     (enter_req),
    .leave     (exit_req),
    .long_en   (long_en),
    .wide_mode (wide_mode),
    .code_sel  (code_sel),
    .entry_ip  (entry_ip),
    .entry_sp  (entry_sp),
    .ret_ip    (ret_ip),
    .ret_sp    (ret_sp),
    .fault     (n_fault),
    .cs        (n_cs),
    .ss        (n_ss),
    .base      (n_base),
    .limit     (n_limit),
    .cs_long   (n_long),
    .ip        (n_ip),
    .sp        (n_sp)
  );

  logic req_any;
  assign req_any = enter_req | exit_req;

  always_ff @(posedge clk) begin
    if (rst || !req_any) begin
      rsp_valid    <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_cs       <= '0;
      rsp_ss       <= '0;
      rsp_cs_base  <= '0;
      rsp_cs_limit <= '0;
      rsp_cs_long  <= 1'b0;
      rsp_ss_base  <= '0;
      rsp_ss_limit <= '0;
      rsp_ip       <= '0;
      rsp_sp       <= '0;
    end else begin
      rsp_valid    <= 1'b1;
      rsp_fault    <= n_fault;
      rsp_cs       <= n_cs;
      rsp_ss       <= n_ss;
      rsp_cs_base  <= n_base;
      rsp_cs_limit <= n_limit;
      rsp_cs_long  <= n_long;
      rsp_ss_base  <= n_base;
      rsp_ss_limit <= n_limit;
      rsp_ip       <= n_ip;
      rsp_sp       <= n_sp;
    end
  end

  a_r3_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_any |=> rsp_valid);

  a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !req_any |=> (!rsp_valid && !rsp_fault && rsp_ip == '0 && rsp_cs == '0));

  a_r9_fault_zeroes_fields: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_valid && rsp_cs == '0 && rsp_ss == '0 && rsp_ip == '0 &&
                   rsp_sp == '0 && !rsp_cs_long && rsp_cs_limit == '0));

  a_r7_exit_user_level: assert property (@(posedge clk) disable iff (rst)
    (exit_req && !enter_req) |=> (rsp_fault ||
      (rsp_cs[1:0] == 2'b11 && rsp_ss[1:0] == 2'b11 && rsp_cs_long)));

  a_r4_entry_kernel_level: assert property (@(posedge clk) disable iff (rst)
    (enter_req && !exit_req) |=> (rsp_fault ||
      (rsp_cs[1:0] == 2'b00 && rsp_ss[1:0] == 2'b00 && rsp_cs_base == '0 && rsp_ss_limit == '1)));

  a_r5_legacy_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (enter_req && !exit_req && !long_en) |=>
      (rsp_ip[ADDR_W-1:32] == '0 && rsp_sp[ADDR_W-1:32] == '0 && !rsp_fault));

  a_r10_double_request: assert property (@(posedge clk) disable iff (rst)
    (enter_req && exit_req) |=> (rsp_valid && rsp_fault));
endmodule

// File: tb/fastcall_xfer_bench.sv
module fastcall_xfer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_idx;
  logic [63:0] cfg_wdata;
  logic        long_en, wide_mode, enter_req, exit_req;
  logic [63:0] ret_ip, ret_sp;
  logic        rsp_valid, rsp_fault, rsp_cs_long;
  logic [15:0] rsp_cs, rsp_ss;
  logic [31:0] rsp_cs_base, rsp_cs_limit, rsp_ss_base, rsp_ss_limit;
  logic [63:0] rsp_ip, rsp_sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  fastcall_xfer u_fastcall_xfer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .long_en(long_en), .wide_mode(wide_mode), .enter_req(enter_req), .exit_req(exit_req),
    .ret_ip(ret_ip), .ret_sp(ret_sp), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cs(rsp_cs), .rsp_ss(rsp_ss), .rsp_cs_base(rsp_cs_base), .rsp_cs_limit(rsp_cs_limit),
    .rsp_cs_long(rsp_cs_long), .rsp_ss_base(rsp_ss_base), .rsp_ss_limit(rsp_ss_limit),
    .rsp_ip(rsp_ip), .rsp_sp(rsp_sp)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [15:0] m_sel;
  logic [63:0] m_eip, m_esp;

  logic        e_valid, e_fault, e_long;
  logic [15:0] e_cs, e_ss;
  logic [31:0] e_lim;
  logic [63:0] e_ip, e_sp;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit canon(input logic [63:0] a);
    return (a[63:47] == '0) || (a[63:47] == '1);
  endfunction

  function automatic logic [63:0] rand_addr();
    logic [63:0] r;
    r = {$urandom, $urandom};
    case ($urandom % 5)
      0: return {32'h0, r[31:0]};
      1: return {17'h1FFFF, r[46:0]};
      2: return r;
      3: return {17'h0, r[46:0]};
      default: return ($urandom % 2) ? 64'h0000_8000_0000_0000 : 64'hFFFF_7FFF_FFFF_FFFF;
    endcase
  endfunction

  task automatic model(input bit en, input bit ex, input bit la, input bit wm,
                       input logic [63:0] rip, input logic [63:0] rsp_in);
    logic [15:0] t;
    e_valid = en | ex; e_fault = 1'b0; e_long = 1'b0;
    e_cs = '0; e_ss = '0; e_lim = '0; e_ip = '0; e_sp = '0;
    if (en && ex) e_fault = 1'b1;
    else if (en) begin
      if (la && wm && (m_sel[15:2] == '0 || !canon(m_eip) || !canon(m_esp))) e_fault = 1'b1;
      else begin
        e_cs = m_sel & 16'hFFFC;
        t = m_sel + 16'd8;   e_ss = t & 16'hFFFC;
        e_lim = 32'hFFFF_FFFF; e_long = la;
        e_ip = la ? m_eip : {32'h0, m_eip[31:0]};
        e_sp = la ? m_esp : {32'h0, m_esp[31:0]};
      end
    end else if (ex) begin
      if (!canon(rip) || !canon(rsp_in)) e_fault = 1'b1;
      else begin
        t = m_sel + 16'd32; e_cs = t | 16'h3;
        t = m_sel + 16'd40; e_ss = t | 16'h3;
        e_lim = 32'hFFFF_FFFF; e_long = 1'b1;
        e_ip = rip; e_sp = rsp_in;
      end
    end
  endtask

  task automatic cfg_write(input logic [1:0] idx, input logic [63:0] d);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (idx)
      2'd0: m_sel = d[15:0];
      2'd1: m_eip = d;
      2'd2: m_esp = d;
      default: ;
    endcase
  endtask

  task automatic run(input string req, input bit en, input bit ex, input bit la, input bit wm,
                     input logic [63:0] rip, input logic [63:0] rsp_in);
    long_en = la; wide_mode = wm; enter_req = en; exit_req = ex; ret_ip = rip; ret_sp = rsp_in;
    model(en, ex, la, wm, rip, rsp_in);
    @(negedge clk);
    enter_req = 1'b0; exit_req = 1'b0;
    chk(req, "valid", 64'(rsp_valid), 64'(e_valid));
    chk(req, "fault", 64'(rsp_fault), 64'(e_fault));
    chk(req, "cs", 64'(rsp_cs), 64'(e_cs));
    chk(req, "ss", 64'(rsp_ss), 64'(e_ss));
    chk(req, "cs_base", 64'(rsp_cs_base), 64'h0);
    chk(req, "ss_base", 64'(rsp_ss_base), 64'h0);
    chk(req, "cs_limit", 64'(rsp_cs_limit), 64'(e_lim));
    chk(req, "ss_limit", 64'(rsp_ss_limit), 64'(e_lim));
    chk(req, "cs_long", 64'(rsp_cs_long), 64'(e_long));
    chk(req, "ip", rsp_ip, e_ip);
    chk(req, "sp", rsp_sp, e_sp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; cfg_we = 0; cfg_idx = 0; cfg_wdata = 0;
    long_en = 0; wide_mode = 0; enter_req = 0; exit_req = 0; ret_ip = 0; ret_sp = 0;
    m_sel = 0; m_eip = 0; m_esp = 0;
    repeat (3) @(negedge clk);
    chk("R1", "valid_in_reset", 64'(rsp_valid), 64'h0);
    rst = 1'b0;
    // R1: cleared configuration seen through a legacy entry
    run("R1", 1, 0, 0, 0, 0, 0);
    // R3: an idle cycle yields no response
    run("R3", 0, 0, 1, 1, 64'h1234, 64'h5678);
    // R2: program registers, then index 3 must not disturb them
    cfg_write(2'd0, 64'hDEAD_BEEF_0000_0013);
    cfg_write(2'd1, 64'hFFFF_8000_0000_1000);
    cfg_write(2'd2, 64'h0000_7FFF_FFFF_F000);
    cfg_write(2'd3, 64'h0123_4567_89AB_CDEF);
    run("R2", 1, 0, 1, 1, 0, 0);
    // R5: legacy entry truncates pointers
    run("R5", 1, 0, 0, 0, 0, 0);
    // R6: null selector with nonzero privilege bits faults in 64-bit mode only
    cfg_write(2'd0, 64'h3);
    run("R6", 1, 0, 1, 1, 0, 0);
    run("R6", 1, 0, 1, 0, 0, 0);
    // R6: non-canonical entry pointer
    cfg_write(2'd0, 64'h10);
    cfg_write(2'd1, 64'h0000_8000_0000_0000);
    run("R6", 1, 0, 1, 1, 0, 0);
    run("R5", 1, 0, 0, 0, 0, 0);
    // R11: selector wrap on exit
    cfg_write(2'd0, 64'hFFF8);
    run("R11", 0, 1, 1, 1, 64'h0000_7FFF_FFFF_FFFF, 64'hFFFF_8000_0000_0000);
    // R8: non-canonical return pointer
    run("R8", 0, 1, 1, 1, 64'hFFFF_7FFF_FFFF_FFFF, 64'h10);
    // R10: both requests at once
    run("R10", 1, 1, 1, 1, 64'h10, 64'h20);
    // R2: write in the same cycle as a request uses the old value
    cfg_we = 1'b1; cfg_idx = 2'd0; cfg_wdata = 64'h0040;
    run("R2", 0, 1, 1, 1, 64'h100, 64'h200);
    cfg_we = 1'b0; m_sel = 16'h0040;
    run("R7", 0, 1, 1, 1, 64'h100, 64'h200);
    // Random mix
    for (int i = 0; i < 600; i++) begin
      int mode;
      int op;
      bit la, wm;
      if ($urandom % 3 == 0) cfg_write(2'($urandom % 4), ($urandom % 4 == 0) ? 64'($urandom % 8) : rand_addr());
      mode = $urandom % 3;
      la = (mode != 0); wm = (mode == 2);
      op = $urandom % 5;
      if (op == 0) run("R3", 0, 0, la, wm, rand_addr(), rand_addr());
      else if (op <= 2) run(wm ? "R6" : (la ? "R4" : "R5"), 1, 0, la, wm, 0, 0);
      else run(($urandom % 2) ? "R7" : "R8", 0, 1, la, wm, rand_addr(), rand_addr());
    end
    // R1: reset again clears configuration
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    m_sel = 0; m_eip = 0; m_esp = 0;
    run("R1", 1, 0, 1, 0, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule